// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller sits beside a small 8-bit processor core and decides which clock domains run. Software writes a control register that holds a sleep-enable bit and a 3-bit sleep-mode code. When the core executes its sleep instruction it sends a one-cycle pulse. If the enable bit is set and the code names a supported mode, the controller enters sleep and turns off a mode-dependent set of clock enables. The domains are CPU, flash, I/O, ADC and asynchronous timer.

An enabled interrupt wakes the sleeping core. Deep modes accept only internal or level-sensitive external interrupts as wake sources. Modes that stop the main oscillator first wait a programmable start-up time. In every mode the core is then held stalled for four more cycles with all clocks running. After that the controller pulses a resume strobe, and the core carries on after the sleep instruction with its register file and SRAM intact.

A reset request that arrives while the core is asleep, waiting for start-up or held takes a shorter path. The controller returns to run at once, clears the control register and flags the resume as a reset-vector restart. All clock-enable outputs are registered and change only on state transitions.

Top module: `slpctl_top`

## Requirements
- R1: A sleep pulse enters sleep only when control bit 0 (enable) is 1. With the bit at 0, or with a mode code of 100, 101 or 111 in bits 3:1, the pulse is ignored: the core is not stalled and all clock enables stay 1.
- R2: The control register reads back as {mode[2:0], enable} on bits 3:1 and bit 0. It resets to 0 and is cleared by a reset request.
- R3: Mode 000 (Idle) turns off the CPU and flash clock enables and keeps I/O, ADC and asynchronous enables at 1.
- R4: Mode 001 (ADC noise reduction) turns off CPU, flash and I/O and keeps ADC and asynchronous at 1.
- R5: Modes 010 (power-down) and 110 (standby) turn off all five enables. Mode 011 (power-save) turns off all except the asynchronous enable.
- R6: In Idle and ADC noise reduction, an internal, level or edge interrupt wakes the core. In modes 010, 011 and 110 an edge interrupt is ignored, and only internal or level interrupts wake it.
- R7: Power-down and power-save add the programmed start-up count of cycles before the hold. The other modes add none.
- R8: After any start-up wait, the core stays stalled for exactly 4 cycles with all enables at 1. The resume strobe then pulses for one cycle with the reset flag at 0.
- R9: A reset request while the core is stalled returns it to run on the next edge with all enables at 1, the resume strobe at 1 and the reset flag at 1.
- R10: When a reset request and a wake interrupt arrive in the same cycle, the reset path wins.
- R11: While running, the core is not stalled and all clock enables are 1. This is also the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Write data {mode, enable} |
| reg_rdata | output | 4 | Read data {mode, enable} |
| startup_cycles | input | CNT_W | Start-up wait for oscillator-stopping modes |
| sleep_pulse | input | 1 | One-cycle sleep instruction strobe |
| irq_int | input | 1 | Enabled internal interrupt pending |
| irq_edge | input | 1 | Enabled edge-triggered external interrupt pending |
| irq_level | input | 1 | Enabled level-sensitive external interrupt pending |
| rst_req | input | 1 | Reset request from a reset source |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| core_stall | output | 1 | Core must not execute |
| resume_pulse | output | 1 | One-cycle strobe when the core may run again |
| resume_reset | output | 1 | With resume_pulse: restart at reset vector |

## Verification
Two of the block's functions can fall in the same cycle: a reset request and an interrupt wake. The bench puts the core into Idle and then raises rst_req and irq_int on the same falling edge. It expects the reset outcome on the next edge: stall released, resume strobe and reset flag both high, and the register cleared. A hold sequence would instead show the stall still high. A register write that lands together with a sleep pulse while the enable bit is still 0 is also checked, and the pulse must be ignored.

// File: rtl/slpctl_pkg.sv
// Shared types and decode functions for the sleep controller.
// Assumes mode codes are 3 bits wide and that there are five clock domains.
package slpctl_pkg;

    localparam int MODE_W      = 3;
    localparam int HOLD_CYCLES = 4;
    localparam int NUM_DOM     = 5;

    localparam logic [MODE_W-1:0] MODE_IDLE  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_ADCNR = 3'b001;
    localparam logic [MODE_W-1:0] MODE_PDOWN = 3'b010;
    localparam logic [MODE_W-1:0] MODE_PSAVE = 3'b011;
    localparam logic [MODE_W-1:0] MODE_STBY  = 3'b110;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_STARTUP = 2'd2,
        ST_HOLD    = 2'd3
    } seq_state_e;

    // Bit order of the enable vector: {cpu, flash, io, adc, asy}
    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic asy;
    } dom_en_t;

    // True for the codes that name a supported sleep mode
    function automatic logic mode_valid(input logic [MODE_W-1:0] m);
        return (m == MODE_IDLE) || (m == MODE_ADCNR) || (m == MODE_PDOWN) ||
               (m == MODE_PSAVE) || (m == MODE_STBY);
    endfunction

    // Deep modes accept no edge-triggered external wake
    function automatic logic mode_deep(input logic [MODE_W-1:0] m);
        return (m == MODE_PDOWN) || (m == MODE_PSAVE) || (m == MODE_STBY);
    endfunction

    // Modes that stop the main oscillator and need a start-up wait
    function automatic logic mode_osc_off(input logic [MODE_W-1:0] m);
        return (m == MODE_PDOWN) || (m == MODE_PSAVE);
    endfunction

    // Clock domains left running while asleep in mode m
    function automatic dom_en_t mode_gating(input logic [MODE_W-1:0] m);
        dom_en_t e;
        e = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asy: 1'b0};
        case (m)
            MODE_IDLE:  begin e.io = 1'b1; e.adc = 1'b1; e.asy = 1'b1; end
            MODE_ADCNR: begin e.adc = 1'b1; e.asy = 1'b1; end
            MODE_PSAVE: begin e.asy = 1'b1; end
            default:    ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/slpctl_ctrl_reg.sv
// Control register: sleep-enable bit and sleep-mode code.
// Assumes a write and a clear in the same cycle resolve to the clear.
module slpctl_ctrl_reg
    import slpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W:0]   wdata,
    input  logic              clr,
    output logic              sleep_en,
    output logic [MODE_W-1:0] mode
);

    // Hold the register, cleared by block reset or a reset request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sleep_en <= 1'b0;
            mode     <= '0;
        end else if (we) begin
            sleep_en <= wdata[0];
            mode     <= wdata[MODE_W:1];
        end
    end

endmodule

// File: rtl/slpctl_seq.sv
// Sleep sequencer: RUN -> SLEEP -> (STARTUP) -> HOLD -> RUN, with reset bypass.
// Assumes the interrupt inputs are already masked by their enables.
// Publishes its next state and next mode so the enables can be registered
// on the same edge as the state.
module slpctl_seq
    import slpctl_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_pulse,
    input  logic              sleep_en,
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  startup_cycles,
    input  logic              irq_int,
    input  logic              irq_edge,
    input  logic              irq_level,
    input  logic              rst_req,
    output seq_state_e        state_nxt,
    output logic [MODE_W-1:0] mode_nxt,
    output logic              core_stall,
    output logic              resume_pulse,
    output logic              resume_reset
);

    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

    seq_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [MODE_W-1:0] mode_q;
    logic              pulse_n, rreset_n, wake;

    // Wake qualification: edge interrupts only count in light modes
    assign wake = irq_int || irq_level || (irq_edge && !mode_deep(mode_q));

    // Next-state, counter and strobe decision
    always_comb begin
        state_nxt = st_q;
        cnt_n     = cnt_q;
        mode_nxt  = mode_q;
        pulse_n   = 1'b0;
        rreset_n  = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (sleep_pulse && sleep_en && mode_valid(mode) && !rst_req) begin
                    state_nxt = ST_SLEEP;
                    mode_nxt  = mode;
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    if (mode_osc_off(mode_q) && (startup_cycles != '0)) begin
                        state_nxt = ST_STARTUP;
                        cnt_n     = startup_cycles - 1'b1;
                    end else begin
                        state_nxt = ST_HOLD;
                        cnt_n     = HOLD_LOAD;
                    end
                end
            end
            ST_STARTUP: begin
                if (cnt_q == '0) begin
                    state_nxt = ST_HOLD;
                    cnt_n     = HOLD_LOAD;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_nxt = ST_RUN;
                    pulse_n   = 1'b1;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_nxt = ST_RUN;
        endcase
        if (rst_req && (st_q != ST_RUN)) begin
            state_nxt = ST_RUN;
            cnt_n     = '0;
            pulse_n   = 1'b1;
            rreset_n  = 1'b1;
        end
    end

    // State, counter, latched mode and resume strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_RUN;
            cnt_q        <= '0;
            mode_q       <= '0;
            resume_pulse <= 1'b0;
            resume_reset <= 1'b0;
        end else begin
            st_q         <= state_nxt;
            cnt_q        <= cnt_n;
            mode_q       <= mode_nxt;
            resume_pulse <= pulse_n;
            resume_reset <= rreset_n;
        end
    end

    assign core_stall = (st_q != ST_RUN);

endmodule

// File: rtl/slpctl_clkgate.sv
// Registered per-domain clock enables derived from the next sequencer state.
// Assumes enables drive glitch-free gating cells, so each is a flop output.
module slpctl_clkgate
    import slpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_nxt,
    input  logic [MODE_W-1:0] mode_nxt,
    output logic [NUM_DOM-1:0] en
);

    dom_en_t target;

    // Asleep or starting up: mode gating; otherwise every domain runs
    always_comb begin
        if ((state_nxt == ST_SLEEP) || (state_nxt == ST_STARTUP))
            target = mode_gating(mode_nxt);
        else
            target = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, asy: 1'b1};
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        // One enable flop per domain, set on reset
        always_ff @(posedge clk) begin
            if (!rst_n) en[d] <= 1'b1;
            else        en[d] <= target[d];
        end
    end

endmodule

// File: rtl/slpctl_top.sv
// Sleep mode clock gating controller top level.
// Assumes one clock domain for the controller itself and that the
// interrupt inputs are already masked by their enables.
module slpctl_top
    import slpctl_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_wdata,
    output logic [3:0]       reg_rdata,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic             sleep_pulse,
    input  logic             irq_int,
    input  logic             irq_edge,
    input  logic             irq_level,
    input  logic             rst_req,
    output logic             clk_en_cpu,
    output logic             clk_en_flash,
    output logic             clk_en_io,
    output logic             clk_en_adc,
    output logic             clk_en_async,
    output logic             core_stall,
    output logic             resume_pulse,
    output logic             resume_reset
);

    logic              sleep_en;
    logic [MODE_W-1:0] mode, mode_nxt;
    seq_state_e        state_nxt;
    dom_en_t           en;

    slpctl_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .clr      (rst_req),
        .sleep_en (sleep_en),
        .mode     (mode)
    );

    slpctl_seq #(.CNT_W(CNT_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_pulse    (sleep_pulse),
        .sleep_en       (sleep_en),
        .mode           (mode),
        .startup_cycles (startup_cycles),
        .irq_int        (irq_int),
        .irq_edge       (irq_edge),
        .irq_level      (irq_level),
        .rst_req        (rst_req),
        .state_nxt      (state_nxt),
        .mode_nxt       (mode_nxt),
        .core_stall     (core_stall),
        .resume_pulse   (resume_pulse),
        .resume_reset   (resume_reset)
    );

    slpctl_clkgate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .mode_nxt  (mode_nxt),
        .en        (en)
    );

    assign reg_rdata    = {mode, sleep_en};
    assign clk_en_cpu   = en.cpu;
    assign clk_en_flash = en.flash;
    assign clk_en_io    = en.io;
    assign clk_en_adc   = en.adc;
    assign clk_en_async = en.asy;

endmodule

// File: rtl/slpctl_chk.sv
// Port-level properties of the sleep controller, attached by bind.
// Assumes it sees only the top-level ports.
module slpctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] reg_rdata,
    input logic       sleep_pulse,
    input logic       rst_req,
    input logic       clk_en_cpu,
    input logic       clk_en_flash,
    input logic       clk_en_io,
    input logic       clk_en_adc,
    input logic       clk_en_async,
    input logic       core_stall,
    input logic       resume_pulse,
    input logic       resume_reset
);

    // R1: a pulse with the enable bit clear leaves the core running
    a_r1_no_entry_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && sleep_pulse && !reg_rdata[0]) |=> !core_stall);

    // R3: entering Idle gates only CPU and flash
    a_r3_idle_gating: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_stall) && ($past(reg_rdata[3:1]) == 3'b000)) |->
        (!clk_en_cpu && !clk_en_flash && clk_en_io && clk_en_adc && clk_en_async));

    // R5: entering power-down gates every domain
    a_r5_pdown_gating: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_stall) && ($past(reg_rdata[3:1]) == 3'b010)) |->
        (!clk_en_cpu && !clk_en_flash && !clk_en_io && !clk_en_adc && !clk_en_async));

    // R8: an interrupt resume follows four stalled cycles with clocks on
    a_r8_hold_four: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_stall) && !resume_reset) |->
        (resume_pulse && $past(core_stall, 4) && $past(clk_en_cpu, 4)));

    // R9: a reset request while stalled returns to run at once
    a_r9_reset_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && core_stall) |=> (!core_stall && resume_pulse && resume_reset
                                     && (reg_rdata == 4'd0)));

    // R11: while running every clock enable is on
    a_r11_run_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        !core_stall |-> (clk_en_cpu && clk_en_flash && clk_en_io && clk_en_adc
                         && clk_en_async));

endmodule

bind slpctl_top slpctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .sleep_pulse  (sleep_pulse),
    .rst_req      (rst_req),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_flash (clk_en_flash),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .clk_en_async (clk_en_async),
    .core_stall   (core_stall),
    .resume_pulse (resume_pulse),
    .resume_reset (resume_reset)
);

// File: tb/slpctl_tb_top.sv
// Directed bench for the sleep controller: one task per scenario.
module slpctl_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_wdata = '0;
    logic [3:0]       reg_rdata;
    logic [CNT_W-1:0] startup_cycles = '0;
    logic             sleep_pulse = 1'b0;
    logic             irq_int = 1'b0, irq_edge = 1'b0, irq_level = 1'b0;
    logic             rst_req = 1'b0;
    logic             clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async;
    logic             core_stall, resume_pulse, resume_reset;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slpctl_top #(.CNT_W(CNT_W)) dut_i (.*);

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clks();
        return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async};
    endfunction

    task automatic write_reg(input logic en, input logic [2:0] m);
        @(negedge clk); reg_we = 1'b1; reg_wdata = {m, en};
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic do_sleep();
        @(negedge clk); sleep_pulse = 1'b1;
        @(negedge clk); sleep_pulse = 1'b0;
    endtask

    // Raise one wake source and count stalled edges until release
    task automatic wake_count(input int src, output int held, output logic rp,
                              output logic rr);
        int n = 0;
        @(negedge clk);
        if (src == 0) irq_int = 1'b1; else irq_level = 1'b1;
        do begin
            @(posedge clk); #1; n++;
            irq_int = 1'b0; irq_level = 1'b0;
        end while (core_stall && n < 100);
        held = n - 1; rp = resume_pulse; rr = resume_reset;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(reg_rdata == 4'd0, "R2", "reset register", reg_rdata, 0);
        check(!core_stall && clks() == 31, "R11", "reset run state",
              {core_stall, clks()}, 31);
    endtask

    task automatic t_register();
        write_reg(1'b1, 3'b011);
        check(reg_rdata == 4'b0111, "R2", "readback", reg_rdata, 7);
        write_reg(1'b0, 3'b000);
    endtask

    task automatic t_disabled();
        write_reg(1'b0, 3'b010);
        // write enable in same cycle as pulse: old value 0 governs
        @(negedge clk); sleep_pulse = 1'b1; reg_we = 1'b1; reg_wdata = 4'b0101;
        @(negedge clk); sleep_pulse = 1'b0; reg_we = 1'b0;
        check(!core_stall && clks() == 31, "R1", "pulse with enable 0",
              {core_stall, clks()}, 31);
        write_reg(1'b1, 3'b101);
        do_sleep();
        check(!core_stall && clks() == 31, "R1", "reserved code 101",
              {core_stall, clks()}, 31);
        write_reg(1'b1, 3'b111);
        do_sleep();
        check(!core_stall, "R1", "reserved code 111", core_stall, 0);
    endtask

    task automatic t_light(input logic [2:0] m, input int exp_clk, input string req);
        int held; logic rp, rr;
        write_reg(1'b1, m);
        do_sleep();
        check(core_stall && clks() == exp_clk, req, "sleep gating", clks(), exp_clk);
        // edge interrupt wakes in light modes (R6)
        @(negedge clk); irq_edge = 1'b1;
        @(posedge clk); #1; irq_edge = 1'b0;
        check(core_stall && clks() == 31, "R6", "edge wake to hold", clks(), 31);
        repeat (3) @(posedge clk);
        #1 check(core_stall, "R8", "still held 4th cycle", core_stall, 1);
        @(posedge clk); #1;
        check(!core_stall && resume_pulse && !resume_reset, "R8", "resume strobe",
              {core_stall, resume_pulse, resume_reset}, 2);
        @(posedge clk); #1;
        check(!resume_pulse, "R8", "strobe one cycle", resume_pulse, 0);
        held = 0; rp = 0; rr = 0;
        write_reg(1'b1, m);
        do_sleep();
        wake_count(0, held, rp, rr);
        check(held == 4 && rp && !rr, "R7", "no start-up in light mode", held, 4);
    endtask

    task automatic t_deep(input logic [2:0] m, input int exp_clk, input int n_start,
                          input int exp_held, input string req);
        int held; logic rp, rr;
        startup_cycles = CNT_W'(n_start);
        write_reg(1'b1, m);
        do_sleep();
        check(core_stall && clks() == exp_clk, req, "deep gating", clks(), exp_clk);
        @(negedge clk); irq_edge = 1'b1;
        repeat (3) @(negedge clk);
        irq_edge = 1'b0;
        check(core_stall && clks() == exp_clk, "R6", "edge ignored in deep mode",
              clks(), exp_clk);
        wake_count(1, held, rp, rr);
        check(held == exp_held && rp && !rr, "R7", "start-up plus hold", held, exp_held);
    endtask

    task automatic t_rst_sleep();
        startup_cycles = 8'd20;
        write_reg(1'b1, 3'b010);
        do_sleep();
        @(negedge clk); irq_int = 1'b1;
        @(negedge clk); irq_int = 1'b0;
        check(core_stall && clks() == 0, "R7", "in start-up clocks off", clks(), 0);
        rst_req = 1'b1;
        @(posedge clk); #1;
        check(!core_stall && resume_pulse && resume_reset && clks() == 31, "R9",
              "reset from start-up", {core_stall, resume_pulse, resume_reset}, 3);
        check(reg_rdata == 4'd0, "R2", "reset request clears register", reg_rdata, 0);
        @(negedge clk); rst_req = 1'b0;
    endtask

    task automatic t_collision();
        write_reg(1'b1, 3'b000);
        do_sleep();
        @(negedge clk); rst_req = 1'b1; irq_int = 1'b1;
        @(posedge clk); #1;
        check(!core_stall && resume_pulse && resume_reset, "R10",
              "reset beats interrupt", {core_stall, resume_pulse, resume_reset}, 3);
        @(negedge clk); rst_req = 1'b0; irq_int = 1'b0;
        check(reg_rdata == 4'd0, "R9", "register cleared", reg_rdata, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_register();
        t_disabled();
        t_light(3'b000, 7, "R3");
        t_light(3'b001, 3, "R4");
        t_deep(3'b010, 0, 5, 9, "R5");
        t_deep(3'b011, 1, 0, 4, "R5");
        t_deep(3'b110, 0, 5, 4, "R5");
        t_rst_sleep();
        t_collision();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule